// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel that sits beside a free-running timer counter. It picks one of four event sources: two external pins, a constant low or a constant high. It can pass that source through a two-flop resynchroniser clocked by the timer clock, or use it directly. It then watches for the edge polarity that software has chosen. When a chosen edge is seen, the channel stores the counter value present at that clock edge and raises its interrupt flag. If another edge is captured before software has serviced the flag, a sticky overflow bit records that a stored value was overwritten.

The channel also reports two input levels. The first is the live level of the selected source. The second is a copy of that level taken on each compare-equal strobe from the counter. A mode bit turns capture operation on or off; with it at 0 the channel is left to compare logic outside this block. Software can force a capture without any pin activity: it selects the constant-low source and then switches to the constant-high source, and the channel sees a rising edge.

Servicing is tracked by a two-state machine. IDLE means no capture is waiting. PEND means a capture is waiting and the flag is raised. These transitions are named:
- CAPTURE: IDLE to PEND.
- SERVICE: PEND to IDLE, when the flag is cleared.
- RECAPTURE: PEND to PEND. It sets overflow unless a clear arrives in the same cycle.
- HOLD: stay in the present state.

Top module: `capture_channel`

## Requirements
- R1: After reset the stored capture value is 0, and the flag, the overflow bit and the latched level are all 0.
- R2: The source select code picks the event source: 00 is pin A, 01 is pin B, 10 is constant 0 and 11 is constant 1. `level_o` shows the selected source combinationally.
- R3: The edge mode code sets which edges are captured: 00 captures none, 01 captures rising, 10 captures falling and 11 captures both. An edge of the other polarity changes nothing.
- R4: With resynchronisation off, a qualifying change of the source made between clock edges is captured at the next rising clock edge. The stored value is the `count_i` present at that edge, and it is held until the next capture.
- R5: With `sync_en_i` at 1, the source passes through two flops. A change made between edges is captured at the third rising clock edge after the change, storing the count present at that edge.
- R6: With `capture_en_i` at 0 (compare operation), no edge changes the stored value or the flag.
- R7: A capture sets the flag (CAPTURE). A `flag_clr_i` pulse clears it (SERVICE). When a capture and a clear fall in the same cycle, the flag stays set.
- R8: A capture that occurs while the flag is set, with no clear in that cycle, sets the overflow bit. The overflow bit survives a flag clear. Only `ovf_clr_i` resets it, and a new overflow in the same cycle as `ovf_clr_i` wins.
- R9: On each clock edge with `equ_i` at 1, `latched_o` takes the selected source level. Otherwise it holds its value.
- R10: Switching the source from constant 0 to constant 1 with rising capture enabled produces a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Running timer count |
| in_a_i | input | 1 | External event pin A |
| in_b_i | input | 1 | External event pin B |
| src_sel_i | input | 2 | Event source select |
| sync_en_i | input | 1 | 1 = resynchronise source to clk |
| edge_mode_i | input | 2 | Edge polarity select |
| capture_en_i | input | 1 | 1 = capture operation, 0 = compare operation |
| equ_i | input | 1 | Compare-equal strobe from the counter |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overflow bit |
| cap_val_o | output | CNT_W | Stored capture value |
| flag_o | output | 1 | Capture interrupt flag |
| ovf_o | output | 1 | Sticky capture overflow |
| level_o | output | 1 | Live level of the selected source |
| latched_o | output | 1 | Source level latched on equ_i |

## Verification
The bench targets the edges of the servicing machine. It places a capture in the same cycle as a flag clear, and an overflow in the same cycle as an overflow clear. A design that gives priority to the clear would drop a pending capture or a lost-capture record. It also gives a second capture after an already serviced flag, where a design that ties overflow to stale state would report a false overflow. The capture latency is measured in both the direct and the resynchronised paths: an off-by-one stage would store a count that differs by one step from the expected value. Wrong-polarity edges, compare operation and edge mode 00 are applied to catch a detector that fires on any change. The constant-source switch and the `equ_i` latch confirm that these paths reach the outputs.

// File: rtl/capture_channel_pkg.sv
package capture_channel_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'b00,
        SRC_PIN_B = 2'b01,
        SRC_LOW   = 2'b10,
        SRC_HIGH  = 2'b11
    } src_sel_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } chan_state_e;

endpackage

// File: rtl/cap_src_sel.sv
module cap_src_sel
    import capture_channel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_a_i,
    input  logic       in_b_i,
    input  logic [1:0] src_sel_i,
    input  logic       sync_en_i,
    input  logic       equ_i,
    output logic       level_o,
    output logic       eff_o,
    output logic       latched_o
);
    localparam int LAST = SYNC_STAGES - 1;

    src_sel_e                 sel;
    logic                     raw;
    logic [SYNC_STAGES-1:0]   sync_q;
    logic                     latched_q;

    assign sel = src_sel_e'(src_sel_i);

    // source multiplexer
    always_comb begin
        unique case (sel)
            SRC_PIN_A: raw = in_a_i;
            SRC_PIN_B: raw = in_b_i;
            SRC_LOW:   raw = 1'b0;
            SRC_HIGH:  raw = 1'b1;
            default:   raw = 1'b0;
        endcase
    end

    // resynchroniser chain
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else if (g == 0) begin
                    sync_q[g] <= raw;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    // level snapshot on compare-equal
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched_q <= 1'b0;
        end else if (equ_i) begin
            latched_q <= raw;
        end
    end

    assign level_o   = raw;
    assign eff_o     = sync_en_i ? sync_q[LAST] : raw;
    assign latched_o = latched_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !equ_i |=> $stable(latched_o)); // R9

    AST_LATCH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        equ_i |=> (latched_o == $past(level_o))); // R9

endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
    import capture_channel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic [1:0] edge_mode_i,
    input  logic       arm_i,
    output logic       hit_o
);
    edge_mode_e mode;
    logic       prev_q;
    logic       rise;
    logic       fall;
    logic       match;

    assign mode = edge_mode_e'(edge_mode_i);

    // previous level always tracks, so arming never fakes an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sig_i;
        end
    end

    assign rise = sig_i & ~prev_q;
    assign fall = ~sig_i & prev_q;

    always_comb begin
        unique case (mode)
            EDGE_NONE: match = 1'b0;
            EDGE_RISE: match = rise;
            EDGE_FALL: match = fall;
            EDGE_BOTH: match = rise | fall;
            default:   match = 1'b0;
        endcase
    end

    assign hit_o = arm_i & match;

    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (sig_i != prev_q)); // R3

endmodule

// File: rtl/cap_store.sv
module cap_store
    import capture_channel_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flag_clr_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             flag_o,
    output logic             ovf_o
);
    chan_state_e      state_q;
    chan_state_e      state_d;
    logic [CNT_W-1:0] cap_q;
    logic             ovf_q;
    logic             ovf_d;
    logic             load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cap_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ovf_q   <= ovf_d;
            if (load) begin
                cap_q <= count_i;
            end
        end
    end

    // transitions and outputs
    always_comb begin
        state_d = state_q;
        ovf_d   = ovf_clr_i ? 1'b0 : ovf_q;
        load    = hit_i;
        unique case (state_q)
            CH_IDLE: begin
                if (hit_i) begin
                    state_d = CH_PEND;          // CAPTURE
                end
            end
            CH_PEND: begin
                if (hit_i) begin
                    state_d = CH_PEND;          // RECAPTURE
                    if (!flag_clr_i) begin
                        ovf_d = 1'b1;
                    end
                end else if (flag_clr_i) begin
                    state_d = CH_IDLE;          // SERVICE
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    assign cap_val_o = cap_q;
    assign flag_o    = (state_q == CH_PEND);
    assign ovf_o     = ovf_q;

    AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> flag_o); // R7

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(cap_val_o)); // R4

    AST_OVF_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(flag_o)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o); // R8

endmodule

// File: rtl/capture_channel.sv
module capture_channel
    import capture_channel_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             in_a_i,
    input  logic             in_b_i,
    input  logic [1:0]       src_sel_i,
    input  logic             sync_en_i,
    input  logic [1:0]       edge_mode_i,
    input  logic             capture_en_i,
    input  logic             equ_i,
    input  logic             flag_clr_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             flag_o,
    output logic             ovf_o,
    output logic             level_o,
    output logic             latched_o
);
    logic eff;
    logic hit;

    cap_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_a_i    (in_a_i),
        .in_b_i    (in_b_i),
        .src_sel_i (src_sel_i),
        .sync_en_i (sync_en_i),
        .equ_i     (equ_i),
        .level_o   (level_o),
        .eff_o     (eff),
        .latched_o (latched_o)
    );

    cap_edge_det u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sig_i       (eff),
        .edge_mode_i (edge_mode_i),
        .arm_i       (capture_en_i),
        .hit_o       (hit)
    );

    cap_store #(.CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .count_i    (count_i),
        .flag_clr_i (flag_clr_i),
        .ovf_clr_i  (ovf_clr_i),
        .cap_val_o  (cap_val_o),
        .flag_o     (flag_o),
        .ovf_o      (ovf_o)
    );

    AST_COMPARE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en_i |=> $stable(cap_val_o)); // R6

    AST_MODE_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i == 2'b00) |=> !$rose(flag_o)); // R3

endmodule

// File: tb/test_capture_channel.sv
module test_capture_channel;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic             in_a_i = 1'b0, in_b_i = 1'b0;
    logic [1:0]       src_sel_i = 2'b00;
    logic             sync_en_i = 1'b0;
    logic [1:0]       edge_mode_i = 2'b01;
    logic             capture_en_i = 1'b1;
    logic             equ_i = 1'b0, flag_clr_i = 1'b0, ovf_clr_i = 1'b0;
    logic [CNT_W-1:0] cap_val_o;
    logic             flag_o, ovf_o, level_o, latched_o;

    always #5 clk = ~clk;

    capture_channel #(.CNT_W(CNT_W)) i_capture_channel (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .in_a_i(in_a_i), .in_b_i(in_b_i),
        .src_sel_i(src_sel_i), .sync_en_i(sync_en_i), .edge_mode_i(edge_mode_i),
        .capture_en_i(capture_en_i), .equ_i(equ_i), .flag_clr_i(flag_clr_i),
        .ovf_clr_i(ovf_clr_i), .cap_val_o(cap_val_o), .flag_o(flag_o), .ovf_o(ovf_o),
        .level_o(level_o), .latched_o(latched_o)
    );

    typedef struct {
        int               due;
        logic [CNT_W-1:0] cap;
        logic             flag;
        logic             ovf;
        logic             lvl;
        logic             lat;
        string            tag;
    } exp_t;

    exp_t             sbq[$];
    int               n_chk = 0, n_bad = 0, cyc = 0;
    bit               done = 0;
    logic [CNT_W-1:0] e_cap = '0;
    logic             e_flag = 0, e_ovf = 0, e_lvl = 0, e_lat = 0;

    // driver step: advance one cycle and queue what must be seen in it
    task automatic tick(input string tag);
        @(negedge clk);
        count_i = count_i + 16'd7;
        cyc++;
        sbq.push_back('{cyc, e_cap, e_flag, e_ovf, e_lvl, e_lat, tag});
        #3;
    endtask

    task automatic cmp(input string tag, input string what, input int got, input int want);
        n_chk++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: got %0h expected %0h", tag, what, cyc, got, want);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sbq.size() > 0 && sbq[0].due == cyc) begin
                exp_t it;
                it = sbq.pop_front();
                cmp(it.tag, "cap_val", int'(cap_val_o), int'(it.cap));
                cmp(it.tag, "flag",    int'(flag_o),    int'(it.flag));
                cmp(it.tag, "ovf",     int'(ovf_o),     int'(it.ovf));
                cmp(it.tag, "level",   int'(level_o),   int'(it.lvl));
                cmp(it.tag, "latched", int'(latched_o), int'(it.lat));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #3 rst_n = 1'b1;
        tick("R1"); tick("R1");

        // R2: source select, pin B vs pin A, no capture with mode 00
        edge_mode_i = 2'b00; in_b_i = 1; src_sel_i = 2'b01; e_lvl = 1; tick("R2");
        src_sel_i = 2'b00; e_lvl = 0; tick("R2");
        in_b_i = 0;
        // R3: mode 00 ignores edges
        in_a_i = 1; e_lvl = 1; tick("R3");
        in_a_i = 0; e_lvl = 0; tick("R3");
        // R6: compare operation ignores edges
        capture_en_i = 0; edge_mode_i = 2'b01;
        in_a_i = 1; e_lvl = 1; tick("R6"); tick("R6");
        in_a_i = 0; e_lvl = 0; tick("R6");
        capture_en_i = 1; tick("R6");
        // R4: rising capture, direct path
        in_a_i = 1; e_lvl = 1; e_cap = count_i; e_flag = 1; tick("R4");
        in_a_i = 0; e_lvl = 0; tick("R3");
        flag_clr_i = 1; e_flag = 0; tick("R7");
        flag_clr_i = 0; tick("R7");
        // R3: falling capture on pin B
        edge_mode_i = 2'b10; src_sel_i = 2'b01; tick("R2");
        in_b_i = 1; e_lvl = 1; tick("R3");
        in_b_i = 0; e_lvl = 0; e_cap = count_i; e_flag = 1; tick("R3");
        // R8: both edges, capture while pending
        edge_mode_i = 2'b11;
        in_b_i = 1; e_lvl = 1; e_cap = count_i; e_ovf = 1; tick("R8");
        flag_clr_i = 1; e_flag = 0; tick("R8");
        flag_clr_i = 0;
        in_b_i = 0; e_lvl = 0; e_cap = count_i; e_flag = 1; tick("R3");
        ovf_clr_i = 1; e_ovf = 0; tick("R8");
        ovf_clr_i = 0;
        // R7: capture in same cycle as clear keeps flag, no overflow
        in_b_i = 1; flag_clr_i = 1; e_lvl = 1; e_cap = count_i; tick("R7");
        flag_clr_i = 0;
        // R8: overflow beats overflow clear
        in_b_i = 0; ovf_clr_i = 1; e_lvl = 0; e_cap = count_i; e_ovf = 1; tick("R8");
        ovf_clr_i = 0;
        flag_clr_i = 1; ovf_clr_i = 1; e_flag = 0; e_ovf = 0; tick("R8");
        flag_clr_i = 0; ovf_clr_i = 0;
        // R5: resynchronised path, capture on third edge
        edge_mode_i = 2'b01; src_sel_i = 2'b00; sync_en_i = 1; tick("R5");
        in_a_i = 1; e_lvl = 1; tick("R5");
        tick("R5");
        e_cap = count_i; e_flag = 1; tick("R5");
        in_a_i = 0; e_lvl = 0; tick("R5"); tick("R5"); tick("R5");
        flag_clr_i = 1; e_flag = 0; tick("R7");
        flag_clr_i = 0; sync_en_i = 0; tick("R5");
        // R10: forced capture via constant sources
        src_sel_i = 2'b10; tick("R10");
        src_sel_i = 2'b11; e_lvl = 1; e_cap = count_i; e_flag = 1; tick("R10");
        src_sel_i = 2'b10; e_lvl = 0; tick("R10");
        // R9: level latched on equ
        edge_mode_i = 2'b00; src_sel_i = 2'b11; e_lvl = 1; tick("R9");
        equ_i = 1; e_lat = 1; tick("R9");
        equ_i = 0; src_sel_i = 2'b10; e_lvl = 0; tick("R9");
        equ_i = 1; e_lat = 0; tick("R9");
        equ_i = 0; tick("R9");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule